// File: doc/BRIEF.md
# Receive Descriptor Ring DMA Engine

This block moves received frames from a byte stream into host memory through a ring of descriptors. Each descriptor is four 32-bit words: word 0 holds the ownership flag (bit 31), the end-of-ring flag (bit 28) and the buffer address (bits 24:0); word 2 holds the buffer length; word 3 is the status word the engine writes back. When the first beat of a frame is offered, the engine fetches the current descriptor. If the engine owns it, the beats are packed into 32-bit words and written into the buffer.

Once the frame ends, the engine writes the status word. It then rewrites word 0 with ownership handed back to the host and pulses the receive interrupt. The status word holds the stored length (the 4 trailing checksum bytes included), the source port, a destination-address class, checksum-fail, VLAN-tag and packet-type fields.

When the descriptor is still host-owned, the whole frame is swallowed and a descriptor-error pulse is raised. The frame stream follows valid/ready rules: a beat moves when `s_valid` and `s_ready` are both high. `s_ready` stays low while a descriptor is being fetched, while a packed word waits for memory and while the status is being written. The memory port uses request/grant in the same way, and the engine holds each request unchanged until it is granted.

Top module: `rx_desc_ring_dma`

## Requirements
- R1: After reset `s_ready`, `mem_req`, `rx_irq` and `desc_err` are low and the current descriptor is the one at `ring_base`.
- R2: When `s_valid` is seen while idle, the engine reads the descriptor word at byte offset 0 (descriptor address = `ring_base` + 16 × index). If bit 31 of that word is 1 (engine-owned), it then reads the word at offset 8. No beat is accepted before these reads finish.
- R3: Byte k of a frame goes to the word at (word-0 bits 24:2, low two bits taken as zero) + 4 × (k/4), in data bits 8×(k%4)+7 down to 8×(k%4), with `mem_be` bit k%4 set. There is one write per word, and a partial final word enables only its filled lanes.
- R4: The buffer limit is bits 10:0 of the word at offset 8. Beats beyond the limit are accepted and discarded, and the length field gives the number of bytes stored.
- R5: After the data, the word at offset 12 is written with these fields:
  - bits 26:16 hold the length;
  - bits 14:12 hold the source port;
  - bits 5:4 hold the destination-address class;
  - bit 3 is the checksum-fail flag;
  - bit 2 is the VLAN-tag flag;
  - bits 1:0 hold the packet type (0 IP, 1 PPPoE);
  - all other bits are zero.
  The attributes are taken from the last beat.
- R6: After the status write, the word at offset 0 is rewritten with bit 31 cleared and every other bit as it was read.
- R7: `rx_irq` is a one-cycle pulse, once per stored frame, in the cycle after the ownership write is granted.
- R8: After a stored frame, the next descriptor is at `ring_base` if the end-of-ring bit (bit 28) was set. Otherwise it is 16 bytes further on.
- R9: If word 0 has bit 31 clear, the frame's beats are consumed up to the last one and nothing is written. `desc_err` pulses for one cycle, and the same descriptor is used for the next frame.
- R10: `s_ready` is low while a write waits for `mem_gnt`. A pending memory request keeps its address, write enable and data stable until it is granted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| ring_base | input | 25 | Byte address of descriptor 0 |
| s_valid | input | 1 | Frame beat valid |
| s_ready | output | 1 | Engine accepts the beat |
| s_data | input | 8 | Frame byte |
| s_last | input | 1 | Final beat of the frame |
| s_src | input | 3 | Source port (0 to 5) |
| s_da | input | 2 | Destination-address class |
| s_csum_bad | input | 1 | IP checksum failed |
| s_vlan | input | 1 | VLAN tag present |
| s_ptype | input | 2 | Packet type |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 25 | Byte address, word aligned |
| mem_wdata | output | 32 | Write data |
| mem_be | output | 4 | Byte lane enables |
| mem_gnt | input | 1 | Request accepted this cycle |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data |
| rx_irq | output | 1 | Frame completed pulse |
| desc_err | output | 1 | Frame dropped on host-owned descriptor pulse |

## Verification
Two things can happen on the same beat: the end of a frame and the buffer limit. This happens when the last beat arrives after the buffer is already full, so the beat both closes the frame and is thrown away. The bench provokes this with a 4-byte buffer and a 6-byte frame placed right after an end-of-ring wrap. The scoreboard then expects exactly one data word, a length field of 4 and no write for the discarded beats. A second overlap, a full word closed while earlier writes are still stalled, is driven by pseudo-random grant stalls. That case is judged by the unchanged order of expected memory accesses and by `s_ready` staying low for every cycle a write waits.

// File: rtl/rxr_pkg.sv
package rxr_pkg;
  localparam int ADDR_W     = 25;
  localparam int LEN_W      = 11;
  localparam int WORD_BYTES = 4;
  localparam int OWN_BIT    = 31;
  localparam int EOR_BIT    = 28;
  localparam int OFS_LEN    = 8;
  localparam int OFS_STAT   = 12;

  typedef enum logic [3:0] {
    ST_IDLE, ST_RD0, ST_WT0, ST_RD2, ST_WT2,
    ST_RECV, ST_DROP, ST_WSTAT, ST_WOWN
  } rxr_state_e;

  typedef struct packed {
    logic [2:0] src;
    logic [1:0] da;
    logic       csum_bad;
    logic       vlan;
    logic [1:0] ptype;
  } rxr_attr_t;
endpackage

// File: rtl/rxr_ring_ptr.sv
module rxr_ring_ptr #(
  parameter int ADDR_W = 25,
  parameter int IDX_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] base,
  input  logic              advance,
  input  logic              wrap,
  output logic [ADDR_W-1:0] desc_addr
);
  localparam int STRIDE_LG = 4;

  logic [IDX_W-1:0] idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) idx <= '0;
    else if (advance) idx <= wrap ? '0 : idx + IDX_W'(1);
  end

  assign desc_addr = base + ADDR_W'({idx, {STRIDE_LG{1'b0}}});

  a_r8_wrap_to_base: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && wrap) |=> (idx == '0));
  a_r8_step: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && !wrap) |=> (idx == $past(idx) + IDX_W'(1)));
endmodule

// File: rtl/rxr_byte_packer.sv
module rxr_byte_packer #(
  parameter int LEN_W      = 11,
  parameter int WORD_BYTES = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clear,
  input  logic                    push,
  input  logic                    last,
  input  logic [7:0]              data,
  input  logic [LEN_W-1:0]        limit,
  input  logic                    drain,
  output logic [8*WORD_BYTES-1:0] word,
  output logic [WORD_BYTES-1:0]   be,
  output logic                    pending,
  output logic [LEN_W-2:0]        woff,
  output logic [LEN_W-1:0]        count
);
  localparam int LANE_W = $clog2(WORD_BYTES);

  logic [LANE_W-1:0] lane;
  logic              store;

  assign store = push && (count < limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word <= '0; be <= '0; pending <= 1'b0; woff <= '0; count <= '0; lane <= '0;
    end else if (clear) begin
      word <= '0; be <= '0; pending <= 1'b0; woff <= '0; count <= '0; lane <= '0;
    end else begin
      if (drain) begin
        word    <= '0;
        be      <= '0;
        lane    <= '0;
        pending <= 1'b0;
        woff    <= woff + (LEN_W-1)'(1);
      end
      if (store) begin
        word[lane*8 +: 8] <= data;
        be[lane]          <= 1'b1;
        lane              <= lane + LANE_W'(1);
        count             <= count + LEN_W'(1);
        if (lane == LANE_W'(WORD_BYTES-1) || last) pending <= 1'b1;
      end else if (push && last && (be != '0)) begin
        pending <= 1'b1;
      end
    end
  end

  a_r4_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    count <= limit);
  a_r3_be_contig: assert property (@(posedge clk) disable iff (!rst_n)
    pending |-> ((be & (be + WORD_BYTES'(1))) == '0) && (be != '0));
endmodule

// File: rtl/rxr_status_word.sv
module rxr_status_word
  import rxr_pkg::*;
(
  input  logic [LEN_W-1:0] len,
  input  rxr_attr_t        attr,
  output logic [31:0]      status
);
  always_comb begin
    status        = '0;
    status[26:16] = len;
    status[14:12] = attr.src;
    status[5:4]   = attr.da;
    status[3]     = attr.csum_bad;
    status[2]     = attr.vlan;
    status[1:0]   = attr.ptype;
  end
endmodule

// File: rtl/rx_desc_ring_dma.sv
module rx_desc_ring_dma
  import rxr_pkg::*;
#(
  parameter int IDX_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] ring_base,
  input  logic              s_valid,
  output logic              s_ready,
  input  logic [7:0]        s_data,
  input  logic              s_last,
  input  logic [2:0]        s_src,
  input  logic [1:0]        s_da,
  input  logic              s_csum_bad,
  input  logic              s_vlan,
  input  logic [1:0]        s_ptype,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [31:0]       mem_wdata,
  output logic [3:0]        mem_be,
  input  logic              mem_gnt,
  input  logic              mem_rvalid,
  input  logic [31:0]       mem_rdata,
  output logic              rx_irq,
  output logic              desc_err
);
  rxr_state_e        state, nxt;
  logic [31:0]       own_word_q;
  logic [LEN_W-1:0]  limit_q;
  logic              got_last;
  rxr_attr_t         attr_q;
  logic              push, drain, advance;
  logic [ADDR_W-1:0] desc_addr;
  logic [31:0]       pk_word, status;
  logic [3:0]        pk_be;
  logic              pk_pend;
  logic [LEN_W-2:0]  pk_woff;
  logic [LEN_W-1:0]  pk_count;
  logic [ADDR_W-1:0] buf_base;

  assign s_ready  = ((state == ST_RECV) && !pk_pend && !got_last) || (state == ST_DROP);
  assign push     = s_valid && s_ready;
  assign drain    = (state == ST_RECV) && pk_pend && mem_gnt;
  assign advance  = (state == ST_WOWN) && mem_gnt;
  assign buf_base = {own_word_q[ADDR_W-1:2], 2'b00};

  rxr_ring_ptr #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_ptr (
    .clk(clk), .rst_n(rst_n), .base(ring_base), .advance(advance),
    .wrap(own_word_q[EOR_BIT]), .desc_addr(desc_addr));

  rxr_byte_packer #(.LEN_W(LEN_W), .WORD_BYTES(WORD_BYTES)) u_pack (
    .clk(clk), .rst_n(rst_n), .clear(state == ST_IDLE),
    .push(push && (state == ST_RECV)), .last(s_last), .data(s_data),
    .limit(limit_q), .drain(drain), .word(pk_word), .be(pk_be),
    .pending(pk_pend), .woff(pk_woff), .count(pk_count));

  rxr_status_word u_stat (.len(pk_count), .attr(attr_q), .status(status));

  always_comb begin
    nxt = state;
    case (state)
      ST_IDLE:  if (s_valid) nxt = ST_RD0;
      ST_RD0:   if (mem_gnt) nxt = ST_WT0;
      ST_WT0:   if (mem_rvalid) nxt = mem_rdata[OWN_BIT] ? ST_RD2 : ST_DROP;
      ST_RD2:   if (mem_gnt) nxt = ST_WT2;
      ST_WT2:   if (mem_rvalid) nxt = ST_RECV;
      ST_RECV:  if (got_last && !pk_pend) nxt = ST_WSTAT;
      ST_DROP:  if (push && s_last) nxt = ST_IDLE;
      ST_WSTAT: if (mem_gnt) nxt = ST_WOWN;
      ST_WOWN:  if (mem_gnt) nxt = ST_IDLE;
      default:  nxt = ST_IDLE;
    endcase
  end

  always_comb begin
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = desc_addr;
    mem_wdata = '0;
    mem_be    = 4'hF;
    case (state)
      ST_RD0:  mem_req = 1'b1;
      ST_RD2: begin
        mem_req  = 1'b1;
        mem_addr = desc_addr + ADDR_W'(OFS_LEN);
      end
      ST_RECV: begin
        mem_req   = pk_pend;
        mem_we    = 1'b1;
        mem_addr  = buf_base + ADDR_W'({pk_woff, 2'b00});
        mem_wdata = pk_word;
        mem_be    = pk_be;
      end
      ST_WSTAT: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = desc_addr + ADDR_W'(OFS_STAT);
        mem_wdata = status;
      end
      ST_WOWN: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_wdata = {1'b0, own_word_q[30:0]};
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      own_word_q <= '0;
      limit_q    <= '0;
      got_last   <= 1'b0;
      attr_q     <= '0;
      rx_irq     <= 1'b0;
      desc_err   <= 1'b0;
    end else begin
      state    <= nxt;
      rx_irq   <= advance;
      desc_err <= (state == ST_WT0) && mem_rvalid && !mem_rdata[OWN_BIT];
      if (state == ST_WT0 && mem_rvalid) own_word_q <= mem_rdata;
      if (state == ST_WT2 && mem_rvalid) limit_q <= mem_rdata[LEN_W-1:0];
      if (state == ST_IDLE) got_last <= 1'b0;
      else if (state == ST_RECV && push && s_last) begin
        got_last <= 1'b1;
        attr_q   <= '{src: s_src, da: s_da, csum_bad: s_csum_bad,
                      vlan: s_vlan, ptype: s_ptype};
      end
    end
  end

  a_r7_irq_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    rx_irq |=> !rx_irq);
  a_r9_err_excl: assert property (@(posedge clk) disable iff (!rst_n)
    desc_err |-> !rx_irq);
  a_r6_own_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    rx_irq |-> $past(mem_req && mem_gnt && mem_we && !mem_wdata[OWN_BIT]));
  a_r10_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)
                               && $stable(mem_wdata)));
  a_r10_stall_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we && !mem_gnt) |-> !s_ready);
endmodule

// File: tb/rx_desc_ring_dma_tb_top.sv
`timescale 1ns/1ps
module rx_desc_ring_dma_tb_top;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst_n;
  logic [24:0] ring_base;
  logic        s_valid, s_ready, s_last, s_csum_bad, s_vlan;
  logic [7:0]  s_data;
  logic [2:0]  s_src;
  logic [1:0]  s_da, s_ptype;
  logic        mem_req, mem_we, mem_gnt, mem_rvalid;
  logic [24:0] mem_addr;
  logic [31:0] mem_wdata, mem_rdata;
  logic [3:0]  mem_be;
  logic        rx_irq, desc_err;

  rx_desc_ring_dma dut_i (
    .clk(clk), .rst_n(rst_n), .ring_base(ring_base),
    .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data), .s_last(s_last),
    .s_src(s_src), .s_da(s_da), .s_csum_bad(s_csum_bad), .s_vlan(s_vlan),
    .s_ptype(s_ptype), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_be(mem_be), .mem_gnt(mem_gnt),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata), .rx_irq(rx_irq),
    .desc_err(desc_err));

  typedef struct {
    bit          we;
    logic [24:0] addr;
    logic [31:0] data;
    logic [3:0]  be;
    string       tag;
  } exp_t;

  localparam logic [24:0] BASE = 25'h100;

  exp_t        exp_q[$];
  int          n_cmp = 0, n_bad = 0;
  int          irq_seen = 0, err_seen = 0, irq_exp = 0, err_exp = 0;
  bit          stall_en = 1'b0, finished = 1'b0;
  logic [7:0]  lfsr = 8'h5A;
  logic [31:0] mem [0:1023];
  logic        poke_en = 1'b0;
  logic [24:0] poke_addr = '0;
  logic [31:0] poke_data = '0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // Memory model and scoreboard monitor: one process owns the array.
  initial begin
    bit          rd_pend;
    logic [24:0] rd_addr;
    rd_pend = 1'b0; rd_addr = '0;
    mem_gnt = 1'b0; mem_rvalid = 1'b0; mem_rdata = '0;
    for (int i = 0; i < 1024; i++) mem[i] = '0;
    forever begin
      @(negedge clk);
      if (poke_en) mem[poke_addr[11:2]] = poke_data;
      if (rd_pend) begin
        mem_rvalid = 1'b1; mem_rdata = mem[rd_addr[11:2]]; rd_pend = 1'b0;
      end else begin
        mem_rvalid = 1'b0;
      end
      if (rx_irq) irq_seen++;
      if (desc_err) err_seen++;
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      mem_gnt = !(stall_en && lfsr[0]);
      if (mem_req && mem_we && !mem_gnt)
        chk(!s_ready, "R10", "s_ready during stalled write", 32'(s_ready), 32'h0);
      if (mem_req && mem_gnt) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R9", "unexpected access addr", 32'(mem_addr), 32'h0);
        end else begin
          exp_t        e;
          logic [31:0] m;
          bit          ok;
          e = exp_q.pop_front();
          m = {{8{e.be[3]}}, {8{e.be[2]}}, {8{e.be[1]}}, {8{e.be[0]}}};
          ok = (mem_we == e.we) && (mem_addr == e.addr) &&
               (!e.we || ((mem_be == e.be) && ((mem_wdata & m) == (e.data & m))));
          n_cmp++;
          if (!ok) begin
            n_bad++;
            $display("FAIL %s access: actual we=%0b addr=%h data=%h be=%h expected we=%0b addr=%h data=%h be=%h",
                     e.tag, mem_we, mem_addr, mem_wdata, mem_be, e.we, e.addr, e.data, e.be);
          end
        end
        if (mem_we) begin
          for (int l = 0; l < 4; l++)
            if (mem_be[l]) mem[mem_addr[11:2]][8*l +: 8] = mem_wdata[8*l +: 8];
        end else begin
          rd_pend = 1'b1; rd_addr = mem_addr;
        end
      end
    end
  end

  task automatic poke(input logic [24:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    poke_addr = a; poke_data = d; poke_en = 1'b1;
    @(posedge clk); #1;
    poke_en = 1'b0;
  endtask

  function automatic logic [31:0] own_word(input bit own, input bit eor,
                                           input logic [24:0] buf_a);
    return {own, 2'b00, eor, 3'b000, buf_a};
  endfunction

  task automatic set_desc(input int idx, input bit own, input bit eor,
                          input logic [24:0] buf_a, input int blen);
    logic [24:0] d;
    d = BASE + 25'(idx * 16);
    poke(d, own_word(own, eor, buf_a));
    poke(d + 25'd4, 32'h0);
    poke(d + 25'd8, 32'(blen));
    poke(d + 25'd12, 32'h0);
  endtask

  function automatic void push_exp(input bit we, input logic [24:0] a,
                                   input logic [31:0] d, input logic [3:0] be,
                                   input string tag);
    exp_t e;
    e.we = we; e.addr = a; e.data = d; e.be = be; e.tag = tag;
    exp_q.push_back(e);
  endfunction

  // Driver: predicts every memory access of the frame, then streams it.
  task automatic send_frame(input int idx, input int len, input bit own,
                            input bit eor, input logic [24:0] buf_a, input int blen,
                            input int src, input int da, input bit csum,
                            input bit vlan, input int ptype, input string rtag);
    logic [24:0] d;
    logic [31:0] st;
    int          stored, seed;
    d = BASE + 25'(idx * 16);
    seed = idx * 16 + len;
    push_exp(1'b0, d, '0, 4'hF, rtag);
    if (own) begin
      push_exp(1'b0, d + 25'd8, '0, 4'hF, rtag);
      stored = (len < blen) ? len : blen;
      for (int w = 0; w * 4 < stored; w++) begin
        logic [31:0] wd;
        logic [3:0]  wb;
        wd = '0; wb = '0;
        for (int l = 0; l < 4; l++)
          if (w * 4 + l < stored) begin
            wd[8*l +: 8] = 8'((w * 4 + l) * 7 + seed);
            wb[l] = 1'b1;
          end
        push_exp(1'b1, buf_a + 25'(w * 4), wd, wb, (len > blen) ? "R4" : "R3");
      end
      st = {5'b0, 11'(stored), 1'b0, 3'(src), 6'b0, 2'(da), csum, vlan, 2'(ptype)};
      push_exp(1'b1, d + 25'd12, st, 4'hF, (len > blen) ? "R4" : "R5");
      push_exp(1'b1, d, own_word(1'b0, eor, buf_a), 4'hF, "R6");
      irq_exp++;
    end else begin
      err_exp++;
    end
    for (int k = 0; k < len; k++) begin
      @(negedge clk);
      s_valid = 1'b1; s_data = 8'(k * 7 + seed); s_last = (k == len - 1);
      s_src = 3'(src); s_da = 2'(da); s_csum_bad = csum; s_vlan = vlan;
      s_ptype = 2'(ptype);
      #1;
      while (!s_ready) begin @(negedge clk); #1; end
    end
    @(negedge clk);
    s_valid = 1'b0; s_last = 1'b0;
    while (exp_q.size() != 0) @(negedge clk);
    repeat (4) @(negedge clk);
    chk(irq_seen == irq_exp, "R7", "receive pulses", 32'(irq_seen), 32'(irq_exp));
    chk(err_seen == err_exp, "R9", "descriptor-error pulses", 32'(err_seen), 32'(err_exp));
  endtask

  initial begin
    rst_n = 1'b0; ring_base = BASE;
    s_valid = 1'b0; s_data = '0; s_last = 1'b0; s_src = '0; s_da = '0;
    s_csum_bad = 1'b0; s_vlan = 1'b0; s_ptype = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(s_ready == 1'b0, "R1", "s_ready", 32'(s_ready), 32'h0);
    chk(mem_req == 1'b0, "R1", "mem_req", 32'(mem_req), 32'h0);
    chk(rx_irq == 1'b0, "R1", "rx_irq", 32'(rx_irq), 32'h0);
    chk(desc_err == 1'b0, "R1", "desc_err", 32'(desc_err), 32'h0);
    rst_n = 1'b1;
    set_desc(0, 1'b1, 1'b0, 25'h400, 1550);
    set_desc(1, 1'b1, 1'b0, 25'h600, 1550);
    set_desc(2, 1'b0, 1'b0, 25'h800, 1550);
    set_desc(3, 1'b1, 1'b1, 25'hA00, 10);
    // R1/R2/R3/R5: first frame at ring base, whole words
    send_frame(0, 64, 1'b1, 1'b0, 25'h400, 1550, 2, 1, 1'b0, 1'b1, 1, "R2");
    // R3/R10: partial final word under grant stalls
    stall_en = 1'b1;
    send_frame(1, 13, 1'b1, 1'b0, 25'h600, 1550, 5, 2, 1'b1, 1'b0, 0, "R2");
    // R9: host-owned descriptor drops the frame
    send_frame(2, 9, 1'b0, 1'b0, 25'h800, 1550, 1, 0, 1'b0, 1'b0, 0, "R9");
    set_desc(2, 1'b1, 1'b0, 25'h800, 1550);
    send_frame(2, 8, 1'b1, 1'b0, 25'h800, 1550, 0, 3, 1'b1, 1'b1, 0, "R9");
    // R4: truncation at the buffer limit, end-of-ring descriptor
    send_frame(3, 23, 1'b1, 1'b1, 25'hA00, 10, 4, 1, 1'b0, 1'b0, 1, "R2");
    // R8: wrap to ring base; last beats beyond a full 4-byte buffer
    set_desc(0, 1'b1, 1'b0, 25'h400, 4);
    send_frame(0, 6, 1'b1, 1'b0, 25'h400, 4, 3, 2, 1'b0, 1'b1, 2, "R8");
    stall_en = 1'b0;
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL R7 watchdog: actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule